// File: doc/BRIEF.md
# Phase/Frequency Detector with Programmable Overlap Clear

The block compares two divided clocks, a reference-side divider output and a feedback-side divider output, and turns their relative timing into two pulse outputs. A reference edge raises `up_o` and a feedback edge raises `dn_o`. The leading input's pulse stays high for as long as the lagging edge is late. Once both pulses are high together, they stay high for a programmable overlap window. Then both drop in the same cycle. Because this overlap is never zero, every comparison yields a non-zero pulse on both outputs, so there is no dead zone around the locked condition.

The whole block runs on one fast sampling clock. Divider edges arrive as single-cycle strobes, and all widths are counted in sampling-clock cycles. A 2-bit setting picks the overlap length. An enable input forces both outputs inactive. The charge pump, the dividers and any loop filter sit outside the block.

Top module: `pfd_core`

## Requirements
- R1: A high `ref_stb_i` sampled at a clock edge makes `up_o` high after that edge. A high `fb_stb_i` does the same for `dn_o`.
- R2: Once `up_o` and `dn_o` are both high, they stay high together for exactly K cycles and then fall in the same cycle. K = `abl_sel_i` + 1, so codes 0, 1, 2 and 3 give 1, 2, 3 and 4 cycles.
- R3: If the reference strobe leads the feedback strobe by L cycles, `up_o` is high for L+K cycles and `dn_o` for K cycles. If the feedback strobe leads by L cycles, the widths are swapped.
- R4: Strobes on both inputs in the same cycle produce `up_o` and `dn_o` pulses of equal width K, never zero, for every setting.
- R5: A strobe on an input whose output is already high has no effect on that pulse's width.
- R6: While `en_i` is low, `up_o` and `dn_o` are low from the next cycle on. Strobes are ignored and any overlap in progress is discarded.
- R7: While `rst_i` is high at a clock edge, `up_o` and `dn_o` are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Output enable; low forces both pulses low |
| ref_stb_i | input | 1 | Single-cycle strobe from the reference divider |
| fb_stb_i | input | 1 | Single-cycle strobe from the feedback divider |
| abl_sel_i | input | 2 | Overlap window select, K = value + 1 cycles |
| up_o | output | 1 | Pulse requesting a frequency increase |
| dn_o | output | 1 | Pulse requesting a frequency decrease |

## Verification
The hardest situations to reach are a second strobe landing while its own pulse is still waiting for the lagging input, and an enable drop in the middle of a pulse. From outside, both look like an ordinary width change. The stimulus places a duplicate reference strobe a few cycles inside a long lead and checks that the expected width is unchanged. It also drops the enable one cycle after a reference edge and sends feedback strobes while disabled, then checks that no pulse appears. Leads and lags of several lengths are run under all four window settings, so the width relation is checked for every overlap length.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Width of the overlap window select field.
    parameter int ABL_W = 2;
    // Overlap cycles for select value 0.
    parameter int ABL_BASE = 1;
    // Extra overlap cycles for each step of the select value.
    parameter int ABL_STEP = 1;

    // Longest overlap window any select value can pick.
    localparam int ABL_MAX = ABL_BASE + ABL_STEP * ((1 << ABL_W) - 1);
    // Counter width able to hold the longest window.
    localparam int ABL_CNT_W = $clog2(ABL_MAX + 1);

    // Index of each side in the two-element latch array.
    typedef enum logic {
        SIDE_REF = 1'b0,
        SIDE_FB  = 1'b1
    } pfd_side_e;

    // The pair of detector outputs.
    typedef struct packed {
        logic dn;
        logic up;
    } pfd_pair_t;

    // Maps a select value to its overlap length in cycles.
    function automatic logic [ABL_CNT_W-1:0] abl_window(input logic [ABL_W-1:0] sel);
        int w;
        w = ABL_BASE + ABL_STEP * int'(sel);
        return ABL_CNT_W'(w);
    endfunction

endpackage

// File: rtl/pfd_edge_latch.sv
module pfd_edge_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic stb_i,
    input  logic clr_i,
    output logic q_o
);

    logic q_q;
    logic q_d;

    // Priority: reset or disable, then the common clear, then the strobe.
    // A strobe that arrives while the flop is set leaves it set.
    always_comb begin
        q_d = q_q;
        if (!en_i || clr_i) begin
            q_d = 1'b0;
        end else if (stb_i) begin
            q_d = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_q <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q_o = q_q;

    // R1
    set_from_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(q_q) |-> $past(stb_i));

    // R5
    hold_until_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (q_q && en_i && !clr_i) |=> q_q);

endmodule

// File: rtl/pfd_abl_timer.sv
module pfd_abl_timer
    import pfd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             both_i,
    input  logic [ABL_W-1:0] sel_i,
    output logic             clr_o
);

    logic [ABL_CNT_W-1:0] lim;
    logic [ABL_CNT_W-1:0] cnt_q;
    logic [ABL_CNT_W-1:0] cnt_d;
    logic                 last;

    assign lim  = abl_window(sel_i);
    assign last = (cnt_q == lim - ABL_CNT_W'(1));

    // The clear goes out in the last cycle of the overlap window,
    // so the latches fall at the edge that ends that cycle.
    assign clr_o = both_i && last;

    always_comb begin
        if (!en_i || !both_i || clr_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + ABL_CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2
    cnt_in_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < ABL_CNT_W'(ABL_MAX));

    // R6
    cnt_disable_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             ref_stb_i,
    input  logic             fb_stb_i,
    input  logic [ABL_W-1:0] abl_sel_i,
    output logic             up_o,
    output logic             dn_o
);

    logic [1:0] stb_v;
    logic [1:0] q_v;
    logic       both;
    logic       clr;
    pfd_pair_t  pair;

    assign stb_v[SIDE_REF] = ref_stb_i;
    assign stb_v[SIDE_FB]  = fb_stb_i;

    for (genvar s = 0; s < 2; s++) begin : g_side
        pfd_edge_latch u_latch (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .en_i  (en_i),
            .stb_i (stb_v[s]),
            .clr_i (clr),
            .q_o   (q_v[s])
        );
    end

    assign both = q_v[SIDE_REF] && q_v[SIDE_FB];

    pfd_abl_timer u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .both_i (both),
        .sel_i  (abl_sel_i),
        .clr_o  (clr)
    );

    assign pair.up = q_v[SIDE_REF];
    assign pair.dn = q_v[SIDE_FB];
    assign up_o    = pair.up;
    assign dn_o    = pair.dn;

    // Independent count of consecutive cycles with both outputs high.
    logic [ABL_CNT_W:0] run_q;
    always_ff @(posedge clk_i) begin
        if (rst_i || !(up_o && dn_o)) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R2
    overlap_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        run_q <= (ABL_CNT_W + 1)'(ABL_MAX));

    // R2
    common_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && $past(en_i) && $fell(up_o)) |-> $fell(dn_o));

    // R6
    disable_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!up_o && !dn_o));

    // R7
    reset_low_chk: assert property (@(posedge clk_i)
        rst_i |=> (!up_o && !dn_o));

endmodule

// File: tb/sim_pfd_core.sv
module sim_pfd_core;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic       ref_stb;
    logic       fb_stb;
    logic [1:0] abl_sel;
    logic       up;
    logic       dn;

    always #5 clk = ~clk;

    pfd_core u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .en_i      (en),
        .ref_stb_i (ref_stb),
        .fb_stb_i  (fb_stb),
        .abl_sel_i (abl_sel),
        .up_o      (up),
        .dn_o      (dn)
    );

    typedef struct {
        int    w;
        string tag;
    } exp_t;

    exp_t up_q[$];
    exp_t dn_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: measures pulse widths on the falling edge and pops expectations.
    int up_w = 0;
    int dn_w = 0;
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            if (up) up_w++;
            else if (up_w > 0) begin
                if (up_q.size() == 0) check(1'b0, "unexpected up pulse", up_w, 0);
                else begin
                    e = up_q.pop_front();
                    check(up_w == e.w, e.tag, up_w, e.w);
                end
                up_w = 0;
            end
            if (dn) dn_w++;
            else if (dn_w > 0) begin
                if (dn_q.size() == 0) check(1'b0, "unexpected dn pulse", dn_w, 0);
                else begin
                    e = dn_q.pop_front();
                    check(dn_w == e.w, e.tag, dn_w, e.w);
                end
                dn_w = 0;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: one comparison with a signed lead (positive: reference first).
    task automatic run_case(input int lead, input int sel, input string tag);
        int k;
        int a;
        exp_t e;
        k = sel + 1;
        a = (lead < 0) ? -lead : lead;
        abl_sel = 2'(sel);
        e.tag = tag;
        e.w = (lead > 0) ? a + k : k;
        up_q.push_back(e);
        e.w = (lead < 0) ? a + k : k;
        dn_q.push_back(e);
        ref_stb = (lead >= 0);
        fb_stb  = (lead <= 0);
        idle(1);
        ref_stb = 1'b0;
        fb_stb  = 1'b0;
        if (a > 0) begin
            idle(a - 1);
            if (lead > 0) fb_stb = 1'b1;
            else ref_stb = 1'b1;
            idle(1);
            ref_stb = 1'b0;
            fb_stb  = 1'b0;
        end
        idle(k + 4);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        exp_t e;
        rst = 1'b1; en = 1'b1; ref_stb = 1'b1; fb_stb = 1'b1; abl_sel = 2'd0;
        idle(3);
        // R7: outputs low while reset is held, even with strobes present
        check(!up && !dn, "R7 reset state", int'({up, dn}), 0);
        ref_stb = 1'b0; fb_stb = 1'b0;
        rst = 1'b0;
        idle(2);
        check(!up && !dn, "R7 idle after reset", int'({up, dn}), 0);

        // R1: reference strobe raises up on the next edge
        abl_sel = 2'd3;
        e.w = 3 + 4; e.tag = "R1 R3 up lead 3 sel 3"; up_q.push_back(e);
        e.w = 4;     e.tag = "R1 R3 dn lead 3 sel 3"; dn_q.push_back(e);
        ref_stb = 1'b1; idle(1); ref_stb = 1'b0;
        check(up && !dn, "R1 up set by ref", int'(up), 1);
        idle(2); fb_stb = 1'b1; idle(1); fb_stb = 1'b0;
        check(up && dn, "R1 dn set by fb", int'(dn), 1);
        idle(8);

        // R3: reference leading and feedback leading, several lengths
        run_case(5, 0, "R3 ref lead 5 sel 0");
        run_case(2, 2, "R3 ref lead 2 sel 2");
        run_case(-4, 1, "R3 fb lead 4 sel 1");
        run_case(-1, 3, "R3 fb lead 1 sel 3");

        // R2 R4: in-phase inputs, every window setting
        for (int s = 0; s < 4; s++) run_case(0, s, "R2 R4 in phase");

        // R5: extra reference strobe while up already set
        abl_sel = 2'd0;
        e.w = 6 + 1; e.tag = "R5 duplicate ref ignored"; up_q.push_back(e);
        e.w = 1;     e.tag = "R5 dn after duplicate";    dn_q.push_back(e);
        ref_stb = 1'b1; idle(1); ref_stb = 1'b0;
        idle(2); ref_stb = 1'b1; idle(1); ref_stb = 1'b0;
        idle(2); fb_stb = 1'b1; idle(1); fb_stb = 1'b0;
        idle(6);

        // R6: disable mid-pulse, then strobes while disabled
        abl_sel = 2'd3;
        e.w = 1; e.tag = "R6 up cut by disable"; up_q.push_back(e);
        ref_stb = 1'b1; idle(1); ref_stb = 1'b0;
        en = 1'b0; idle(1);
        check(!up && !dn, "R6 low after disable", int'({up, dn}), 0);
        fb_stb = 1'b1; ref_stb = 1'b1; idle(2); fb_stb = 1'b0; ref_stb = 1'b0;
        check(!up && !dn, "R6 strobes ignored while disabled", int'({up, dn}), 0);
        en = 1'b1; idle(3);
        check(!up && !dn, "R6 nothing latched during disable", int'({up, dn}), 0);
        run_case(1, 1, "R6 normal after re-enable");

        idle(4);
        check(up_q.size() == 0, "R3 up queue drained", up_q.size(), 0);
        check(dn_q.size() == 0, "R3 dn queue drained", dn_q.size(), 0);
        summary();
    end

endmodule